// File: doc/BRIEF.md
# Dual-CPU Mailbox FIFO Controller

This block lets two processors, called side A and side B, exchange 32-bit words and short signals. Each side owns one outbound word queue. It pushes only into its own queue and pops only from the queue the other side owns. Each side also has a 16-bit control register and a 16-bit sync register.

The control register holds a master enable and two interrupt enables. Writing to it can also flush the side's own queue or acknowledge the side's error flag. Reading it shows the fill status of both queues and the error flag. The sync register carries a 4-bit nibble to the other side, an arm bit, and a bit that rings the other side.

Each side has three interrupt request outputs: outbound queue drained, inbound word available, and sync ring. Each request is a single-cycle pulse. A request is raised on a transition, either by the side's own access or by the peer's access. No request is raised by a level.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty and all stored control and sync bits are 0. Each control read value is 0x0101, each sync read value is 0x0000, and all interrupt outputs are low.
- R2: A control write stores only bits 15 (enable), 10 (inbound interrupt enable) and 2 (drained interrupt enable). The read value also has status bits: bit 0 = own queue empty, bit 1 = own queue full, bit 8 = peer queue empty, bit 9 = peer queue full, bit 14 = error flag. All other bits read 0.
- R3: Words pushed by one side are popped by the other side in push order. Each queue holds 16 words. A popped word appears on the pop data output in the cycle after the pop.
- R4: While a side's bit 15 is 0, its pushes and pops are ignored. The queues and the error flag do not change.
- R5: A push to a full queue, or a pop from an empty queue, by an enabled side leaves the queue unchanged and sets that side's error flag. The pop data output keeps the last word actually popped.
- R6: Writing 1 to control bit 14 clears the writer's error flag.
- R7: Writing 1 to control bit 3 empties the writer's own queue. Bit 3 is not stored.
- R8: A control write that moves bit 2 from 0 to 1 raises a drained interrupt on the writer. This happens only if the writer's own queue is empty, or is emptied by the same write.
- R9: A control write that moves bit 10 from 0 to 1 raises an inbound interrupt on the writer, provided the peer's queue holds at least one word.
- R10: A push into an empty queue raises an inbound interrupt on the peer if the peer's bit 10 is set. A push into a non-empty queue raises none.
- R11: A pop that removes the last word of a queue raises a drained interrupt on the queue's owner if the owner's bit 2 is set.
- R12: A sync write stores only bits 14 (arm) and 11:8 (nibble). Sync read bits 3:0 show the peer's stored nibble.
- R13: A sync write with bit 13 set raises a sync interrupt on the peer if the peer's stored arm bit is set.
- R14: Every interrupt output is a one-cycle pulse. It is high in the cycle after the access that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ctl_we | input | 1 | Side A control write strobe |
| a_ctl_wdata | input | 16 | Side A control write value |
| a_sync_we | input | 1 | Side A sync write strobe |
| a_sync_wdata | input | 16 | Side A sync write value |
| a_push | input | 1 | Side A push into its own queue |
| a_push_data | input | 32 | Side A word to push |
| a_pop | input | 1 | Side A pop from side B's queue |
| a_ctl_rd | output | 16 | Side A control read value |
| a_sync_rd | output | 16 | Side A sync read value |
| a_pop_data | output | 32 | Last word popped by side A |
| a_irq_send_empty | output | 1 | Side A drained interrupt pulse |
| a_irq_recv | output | 1 | Side A inbound interrupt pulse |
| a_irq_sync | output | 1 | Side A sync interrupt pulse |
| b_ctl_we | input | 1 | Side B control write strobe |
| b_ctl_wdata | input | 16 | Side B control write value |
| b_sync_we | input | 1 | Side B sync write strobe |
| b_sync_wdata | input | 16 | Side B sync write value |
| b_push | input | 1 | Side B push into its own queue |
| b_push_data | input | 32 | Side B word to push |
| b_pop | input | 1 | Side B pop from side A's queue |
| b_ctl_rd | output | 16 | Side B control read value |
| b_sync_rd | output | 16 | Side B sync read value |
| b_pop_data | output | 32 | Last word popped by side B |
| b_irq_send_empty | output | 1 | Side B drained interrupt pulse |
| b_irq_recv | output | 1 | Side B inbound interrupt pulse |
| b_irq_sync | output | 1 | Side B sync interrupt pulse |

## Verification
The properties assume that every strobe is a clean, single-cycle level that is sampled at the rising edge. They also assume that a flush write is the only way a queue can empty without a pop. The stability and error properties are guarded against same-cycle pops by the peer and same-cycle control writes by the owner, because those accesses change the status they watch.

The directed tasks apply one access per cycle, with an idle cycle between accesses. The one deliberate exception is a control write that flushes the queue and enables the drained interrupt in the same write. Because of this spacing, the interrupt pulses that the bench observes each trace back to a single cause.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
   // control register bit positions
   localparam int CB_OWN_EMPTY = 0;
   localparam int CB_OWN_FULL  = 1;
   localparam int CB_DRAIN_IE  = 2;
   localparam int CB_FLUSH     = 3;
   localparam int CB_PEER_EMPTY = 8;
   localparam int CB_PEER_FULL = 9;
   localparam int CB_INBOUND_IE = 10;
   localparam int CB_ERR       = 14;
   localparam int CB_ON        = 15;
   // sync register bit positions
   localparam int SB_NIB_LO    = 8;
   localparam int SB_RING      = 13;
   localparam int SB_ARM       = 14;
   localparam int NIB_W        = 4;

   typedef struct packed {
      logic inbound;   // push landed in an empty queue
      logic drained;   // pop removed the last word
      logic ring;      // sync ring request
   } kick_t;
endpackage

// File: rtl/ipc_word_fifo.sv
module ipc_word_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic             last
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
   localparam logic [AW:0] ONE_CNT  = (AW+1)'(1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ipc_word_fifo: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("ipc_word_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [AW:0]      cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == FULL_CNT);
   assign last  = (cnt == ONE_CNT);
endmodule

// File: rtl/ipc_side_ctl.sv
module ipc_side_ctl
   import ipc_mailbox_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [15:0]      ctl_wdata,
   input  logic             sync_we,
   input  logic [15:0]      sync_wdata,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic             own_empty,
   input  logic             own_full,
   input  logic             peer_empty,
   input  logic             peer_full,
   input  logic             peer_last,
   input  logic             peer_flush,
   input  logic             peer_do_push,
   input  logic [WIDTH-1:0] peer_head,
   input  logic [NIB_W-1:0] peer_nib,
   input  kick_t            kick_in,
   output logic             do_push,
   output logic             do_pop,
   output logic             flush,
   output kick_t            kick_out,
   output logic [NIB_W-1:0] own_nib,
   output logic [15:0]      ctl_rd,
   output logic [15:0]      sync_rd,
   output logic [WIDTH-1:0] pop_data,
   output logic             irq_drained,
   output logic             irq_inbound,
   output logic             irq_ring
);
   logic on_q, drain_ie_q, inbound_ie_q, err_q, arm_q;
   logic err_set, drain_edge, inbound_edge;
   logic unused_bits;

   assign unused_bits = ^{ctl_wdata[13:11], ctl_wdata[9:4], ctl_wdata[1:0],
                          sync_wdata[15], sync_wdata[12], sync_wdata[7:0]};

   assign flush   = ctl_we & ctl_wdata[CB_FLUSH];
   assign do_push = push_req & on_q & ~flush & ~own_full;
   assign do_pop  = pop_req & on_q & ~peer_flush & ~peer_empty;
   assign err_set = (push_req & on_q & ~flush & own_full) |
                    (pop_req & on_q & ~peer_flush & peer_empty);

   assign kick_out.inbound = do_push & own_empty;
   assign kick_out.drained = do_pop & peer_last & ~peer_do_push;
   assign kick_out.ring    = sync_we & sync_wdata[SB_RING];

   assign drain_edge   = ctl_we & ctl_wdata[CB_DRAIN_IE] & ~drain_ie_q &
                         (own_empty | flush);
   assign inbound_edge = ctl_we & ctl_wdata[CB_INBOUND_IE] & ~inbound_ie_q &
                         ~peer_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q         <= 1'b0;
         drain_ie_q   <= 1'b0;
         inbound_ie_q <= 1'b0;
         err_q        <= 1'b0;
         arm_q        <= 1'b0;
         own_nib      <= '0;
         pop_data     <= '0;
         irq_drained  <= 1'b0;
         irq_inbound  <= 1'b0;
         irq_ring     <= 1'b0;
      end else begin
         if (ctl_we) begin
            on_q         <= ctl_wdata[CB_ON];
            drain_ie_q   <= ctl_wdata[CB_DRAIN_IE];
            inbound_ie_q <= ctl_wdata[CB_INBOUND_IE];
         end
         err_q <= err_set | (err_q & ~(ctl_we & ctl_wdata[CB_ERR]));
         if (sync_we) begin
            arm_q   <= sync_wdata[SB_ARM];
            own_nib <= sync_wdata[SB_NIB_LO +: NIB_W];
         end
         if (do_pop) pop_data <= peer_head;
         irq_drained <= drain_edge | (kick_in.drained & drain_ie_q);
         irq_inbound <= inbound_edge | (kick_in.inbound & inbound_ie_q);
         irq_ring    <= kick_in.ring & arm_q;
      end
   end

   always_comb begin
      ctl_rd                = '0;
      ctl_rd[CB_OWN_EMPTY]  = own_empty;
      ctl_rd[CB_OWN_FULL]   = own_full;
      ctl_rd[CB_DRAIN_IE]   = drain_ie_q;
      ctl_rd[CB_PEER_EMPTY] = peer_empty;
      ctl_rd[CB_PEER_FULL]  = peer_full;
      ctl_rd[CB_INBOUND_IE] = inbound_ie_q;
      ctl_rd[CB_ERR]        = err_q;
      ctl_rd[CB_ON]         = on_q;
      sync_rd                         = '0;
      sync_rd[NIB_W-1:0]              = peer_nib;
      sync_rd[SB_NIB_LO +: NIB_W]     = own_nib;
      sync_rd[SB_ARM]                 = arm_q;
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mailbox_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_ctl_we,
   input  logic [15:0]      a_ctl_wdata,
   input  logic             a_sync_we,
   input  logic [15:0]      a_sync_wdata,
   input  logic             a_push,
   input  logic [WIDTH-1:0] a_push_data,
   input  logic             a_pop,
   output logic [15:0]      a_ctl_rd,
   output logic [15:0]      a_sync_rd,
   output logic [WIDTH-1:0] a_pop_data,
   output logic             a_irq_send_empty,
   output logic             a_irq_recv,
   output logic             a_irq_sync,
   input  logic             b_ctl_we,
   input  logic [15:0]      b_ctl_wdata,
   input  logic             b_sync_we,
   input  logic [15:0]      b_sync_wdata,
   input  logic             b_push,
   input  logic [WIDTH-1:0] b_push_data,
   input  logic             b_pop,
   output logic [15:0]      b_ctl_rd,
   output logic [15:0]      b_sync_rd,
   output logic [WIDTH-1:0] b_pop_data,
   output logic             b_irq_send_empty,
   output logic             b_irq_recv,
   output logic             b_irq_sync
);
   localparam int NSIDE = 2;

   generate
      if (WIDTH < 1 || DEPTH < 2) begin : g_bad_params
         $error("ipc_mailbox: WIDTH must be positive and DEPTH at least 2");
      end
   endgenerate

   logic [NSIDE-1:0]            ctl_we, sync_we, push_req, pop_req;
   logic [NSIDE-1:0][15:0]      ctl_wdata, sync_wdata, ctl_rd, sync_rd;
   logic [NSIDE-1:0][WIDTH-1:0] push_data, head, pop_data;
   logic [NSIDE-1:0]            empty, full, last, flush, do_push, do_pop;
   logic [NSIDE-1:0]            irq_dr, irq_in, irq_rg;
   logic [NSIDE-1:0][NIB_W-1:0] nib;
   kick_t [NSIDE-1:0]           kick;

   assign ctl_we     = {b_ctl_we, a_ctl_we};
   assign sync_we    = {b_sync_we, a_sync_we};
   assign push_req   = {b_push, a_push};
   assign pop_req    = {b_pop, a_pop};
   assign ctl_wdata  = {b_ctl_wdata, a_ctl_wdata};
   assign sync_wdata = {b_sync_wdata, a_sync_wdata};
   assign push_data  = {b_push_data, a_push_data};

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         localparam int P = NSIDE - 1 - s;

         ipc_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush[s]),
            .push  (do_push[s]),
            .pop   (do_pop[P]),
            .din   (push_data[s]),
            .dout  (head[s]),
            .empty (empty[s]),
            .full  (full[s]),
            .last  (last[s])
         );

         ipc_side_ctl #(.WIDTH(WIDTH)) u_ctl (
            .clk          (clk),
            .rst_n        (rst_n),
            .ctl_we       (ctl_we[s]),
            .ctl_wdata    (ctl_wdata[s]),
            .sync_we      (sync_we[s]),
            .sync_wdata   (sync_wdata[s]),
            .push_req     (push_req[s]),
            .pop_req      (pop_req[s]),
            .own_empty    (empty[s]),
            .own_full     (full[s]),
            .peer_empty   (empty[P]),
            .peer_full    (full[P]),
            .peer_last    (last[P]),
            .peer_flush   (flush[P]),
            .peer_do_push (do_push[P]),
            .peer_head    (head[P]),
            .peer_nib     (nib[P]),
            .kick_in      (kick[P]),
            .do_push      (do_push[s]),
            .do_pop       (do_pop[s]),
            .flush        (flush[s]),
            .kick_out     (kick[s]),
            .own_nib      (nib[s]),
            .ctl_rd       (ctl_rd[s]),
            .sync_rd      (sync_rd[s]),
            .pop_data     (pop_data[s]),
            .irq_drained  (irq_dr[s]),
            .irq_inbound  (irq_in[s]),
            .irq_ring     (irq_rg[s])
         );
      end
   endgenerate

   assign a_ctl_rd         = ctl_rd[0];
   assign a_sync_rd        = sync_rd[0];
   assign a_pop_data       = pop_data[0];
   assign a_irq_send_empty = irq_dr[0];
   assign a_irq_recv       = irq_in[0];
   assign a_irq_sync       = irq_rg[0];
   assign b_ctl_rd         = ctl_rd[1];
   assign b_sync_rd        = sync_rd[1];
   assign b_pop_data       = pop_data[1];
   assign b_irq_send_empty = irq_dr[1];
   assign b_irq_recv       = irq_in[1];
   assign b_irq_sync       = irq_rg[1];
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_ctl_we,
   input logic [15:0]      a_ctl_wdata,
   input logic             a_sync_we,
   input logic [15:0]      a_sync_wdata,
   input logic             a_push,
   input logic             a_pop,
   input logic [15:0]      a_ctl_rd,
   input logic [15:0]      a_sync_rd,
   input logic             a_irq_send_empty,
   input logic             a_irq_sync,
   input logic             b_ctl_we,
   input logic [15:0]      b_ctl_wdata,
   input logic             b_sync_we,
   input logic [15:0]      b_sync_wdata,
   input logic             b_pop,
   input logic [15:0]      b_ctl_rd,
   input logic [15:0]      b_sync_rd,
   input logic             b_irq_recv
);
   assert_ctl_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      a_ctl_we |=> (a_ctl_rd[15] == $past(a_ctl_wdata[15])) &&
                   (a_ctl_rd[10] == $past(a_ctl_wdata[10])) &&
                   (a_ctl_rd[2]  == $past(a_ctl_wdata[2])));

   assert_off_holds_queue_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_ctl_rd[15] && !a_ctl_we && !b_pop) |=> $stable(a_ctl_rd[1:0]));

   assert_overflow_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ctl_rd[15] && a_ctl_rd[1] && a_push && !a_ctl_we && !b_pop)
         |=> (a_ctl_rd[14] && a_ctl_rd[1]));

   assert_err_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ctl_we && a_ctl_wdata[14] && !a_push && !a_pop) |=> !a_ctl_rd[14]);

   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_ctl_we && a_ctl_wdata[3]) |=> a_ctl_rd[0]);

   assert_drain_needs_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
      a_irq_send_empty |-> $past(a_ctl_rd[2] || (a_ctl_we && a_ctl_wdata[2])));

   assert_inbound_needs_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
      b_irq_recv |-> $past(b_ctl_rd[10] || (b_ctl_we && b_ctl_wdata[10])));

   assert_nib_cross_R12: assert property (@(posedge clk) disable iff (!rst_n)
      a_sync_we |=> (b_sync_rd[3:0] == $past(a_sync_wdata[11:8])) &&
                    (a_sync_rd[14] == $past(a_sync_wdata[14])));

   assert_ring_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
      a_irq_sync |-> $past(b_sync_we && b_sync_wdata[13]));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        a_ctl_we = 0, a_sync_we = 0, a_push = 0, a_pop = 0;
   logic [15:0] a_ctl_wdata = 0, a_sync_wdata = 0;
   logic [31:0] a_push_data = 0;
   logic        b_ctl_we = 0, b_sync_we = 0, b_push = 0, b_pop = 0;
   logic [15:0] b_ctl_wdata = 0, b_sync_wdata = 0;
   logic [31:0] b_push_data = 0;
   logic [15:0] a_ctl_rd, a_sync_rd, b_ctl_rd, b_sync_rd;
   logic [31:0] a_pop_data, b_pop_data;
   logic a_irq_send_empty, a_irq_recv, a_irq_sync;
   logic b_irq_send_empty, b_irq_recv, b_irq_sync;

   int total = 0;
   int bad = 0;
   bit done = 0;

   ipc_mailbox u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ctl_wr(input int side, input logic [15:0] v);
      @(negedge clk);
      if (side == 0) begin a_ctl_we = 1; a_ctl_wdata = v; end
      else begin b_ctl_we = 1; b_ctl_wdata = v; end
      @(negedge clk);
      a_ctl_we = 0; b_ctl_we = 0;
   endtask

   task automatic sync_wr(input int side, input logic [15:0] v);
      @(negedge clk);
      if (side == 0) begin a_sync_we = 1; a_sync_wdata = v; end
      else begin b_sync_we = 1; b_sync_wdata = v; end
      @(negedge clk);
      a_sync_we = 0; b_sync_we = 0;
   endtask

   task automatic push(input int side, input logic [31:0] v);
      @(negedge clk);
      if (side == 0) begin a_push = 1; a_push_data = v; end
      else begin b_push = 1; b_push_data = v; end
      @(negedge clk);
      a_push = 0; b_push = 0;
   endtask

   task automatic pop(input int side);
      @(negedge clk);
      if (side == 0) a_pop = 1; else b_pop = 1;
      @(negedge clk);
      a_pop = 0; b_pop = 0;
   endtask

   task automatic fresh();
      ctl_wr(0, 16'hC008);
      ctl_wr(1, 16'hC008);
   endtask

   task automatic t_reset();
      chk("R1 a ctl", a_ctl_rd, 32'h0101);
      chk("R1 b ctl", b_ctl_rd, 32'h0101);
      chk("R1 a sync", a_sync_rd, 0);
      chk("R1 b sync", b_sync_rd, 0);
      chk("R1 irqs", {a_irq_send_empty, a_irq_recv, a_irq_sync,
                      b_irq_send_empty, b_irq_recv, b_irq_sync}, 0);
   endtask

   task automatic t_ctl_mask();
      ctl_wr(0, 16'hFBFB);
      chk("R2 only enable kept", a_ctl_rd, 32'h8101);
      chk("R2 no drain irq", a_irq_send_empty, 0);
      ctl_wr(0, 16'h0000);
      chk("R2 cleared", a_ctl_rd, 32'h0101);
   endtask

   task automatic t_order();
      fresh();
      for (int i = 0; i < 16; i++) push(0, 32'hA000_0000 + i);
      chk("R3 own full", a_ctl_rd[1:0], 2'b10);
      chk("R3 peer full seen", b_ctl_rd[9:8], 2'b10);
      for (int i = 0; i < 16; i++) begin
         pop(1);
         chk("R3 order", b_pop_data, 32'hA000_0000 + i);
      end
      chk("R3 drained", a_ctl_rd[1:0], 2'b01);
      chk("R3 no error", b_ctl_rd[14], 0);
   endtask

   task automatic t_disabled();
      fresh();
      ctl_wr(0, 16'h0000);
      push(0, 32'h1111_1111);
      chk("R4 push ignored", a_ctl_rd, 32'h0101);
      ctl_wr(0, 16'h8000);
      push(0, 32'h2222_2222);
      ctl_wr(1, 16'h0000);
      pop(1);
      chk("R4 pop ignored queue", a_ctl_rd[0], 0);
      chk("R4 pop ignored data", b_pop_data, 32'hA000_000F);
      ctl_wr(1, 16'h8000);
      pop(1);
      chk("R4 word after enable", b_pop_data, 32'h2222_2222);
   endtask

   task automatic t_errors();
      fresh();
      for (int i = 0; i < 16; i++) push(0, 32'hB000_0000 + i);
      push(0, 32'hDEAD_BEEF);
      chk("R5 overflow err", a_ctl_rd[14], 1);
      chk("R5 still full", a_ctl_rd[1], 1);
      for (int i = 0; i < 16; i++) begin
         pop(1);
         if (i == 0 || i == 15) chk("R5 contents kept", b_pop_data, 32'hB000_0000 + i);
      end
      chk("R5 no err on valid pops", b_ctl_rd[14], 0);
      pop(1);
      chk("R5 underflow err", b_ctl_rd[14], 1);
      chk("R5 last word held", b_pop_data, 32'hB000_000F);
      ctl_wr(0, 16'hC000);
      chk("R6 ack a", a_ctl_rd[14], 0);
      ctl_wr(1, 16'hC000);
      chk("R6 ack b", b_ctl_rd[14], 0);
   endtask

   task automatic t_flush();
      fresh();
      push(0, 1); push(0, 2); push(0, 3);
      chk("R7 filled", a_ctl_rd[0], 0);
      ctl_wr(0, 16'h8008);
      chk("R7 emptied, bit3 not kept", a_ctl_rd, 32'h8101);
      chk("R7 peer sees empty", b_ctl_rd[8], 1);
   endtask

   task automatic t_drain_enable();
      fresh();
      ctl_wr(0, 16'h8004);
      chk("R8 enable on empty", a_irq_send_empty, 1);
      @(negedge clk);
      chk("R14 pulse one cycle", a_irq_send_empty, 0);
      ctl_wr(0, 16'h8004);
      chk("R8 no edge no irq", a_irq_send_empty, 0);
      ctl_wr(0, 16'h8000);
      push(0, 32'h55);
      ctl_wr(0, 16'h8004);
      chk("R8 non-empty no irq", a_irq_send_empty, 0);
      ctl_wr(0, 16'h8000);
      ctl_wr(0, 16'h800C);
      chk("R8 flush and enable", a_irq_send_empty, 1);
   endtask

   task automatic t_inbound_enable();
      fresh();
      push(0, 32'h77);
      ctl_wr(1, 16'h8400);
      chk("R9 enable with word", b_irq_recv, 1);
      chk("R9 writer only", a_irq_recv, 0);
      pop(1);
      ctl_wr(1, 16'h8000);
      ctl_wr(1, 16'h8400);
      chk("R9 empty no irq", b_irq_recv, 0);
   endtask

   task automatic t_push_irq();
      fresh();
      ctl_wr(1, 16'h8400);
      push(0, 32'h100);
      chk("R10 push into empty", b_irq_recv, 1);
      @(negedge clk);
      chk("R14 inbound pulse ends", b_irq_recv, 0);
      push(0, 32'h101);
      chk("R10 push into non-empty", b_irq_recv, 0);
      pop(1); pop(1);
   endtask

   task automatic t_pop_irq();
      fresh();
      push(0, 32'h200); push(0, 32'h201);
      ctl_wr(0, 16'h8004);
      chk("R8 non-empty enable", a_irq_send_empty, 0);
      pop(1);
      chk("R11 not last", a_irq_send_empty, 0);
      pop(1);
      chk("R11 last word", a_irq_send_empty, 1);
      chk("R11 popper quiet", b_irq_send_empty, 0);
   endtask

   task automatic t_sync();
      sync_wr(0, 16'hFFFF);
      chk("R12 a mask", a_sync_rd, 32'h4F00);
      chk("R12 b sees nibble", b_sync_rd, 32'h000F);
      chk("R13 peer unarmed", b_irq_sync, 0);
      sync_wr(1, 16'h4A00);
      chk("R13 no ring bit", a_irq_sync, 0);
      chk("R12 a sees b nibble", a_sync_rd, 32'h4F0A);
      sync_wr(0, 16'h2300);
      chk("R13 ring armed peer", b_irq_sync, 1);
      chk("R12 b view", b_sync_rd, 32'h4A03);
      sync_wr(1, 16'h2000);
      chk("R13 ring unarmed peer", a_irq_sync, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl_mask();
      t_order();
      t_disabled();
      t_errors();
      t_flush();
      t_drain_enable();
      t_inbound_enable();
      t_push_irq();
      t_pop_irq();
      t_sync();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule